// File: doc/BRIEF.md
# Double-Buffered Filter Coefficient Store

This block keeps two banks of 24-bit signed filter coefficients (1.23 fixed point, 70 entries per bank, known as C1 to C70) for a filter engine that must keep running while its coefficients change. A host reaches the store through a byte-wide register port. Each coefficient spans three byte addresses, and a single control register holds the mode and swap bits. The filter engine reads one coefficient per request from whichever bank is active.

When the engine is stopped, the host addresses either bank directly. When the engine runs with adaptive mode off, coefficient access is locked. When the engine runs with adaptive mode on, every host coefficient access is steered to the bank the engine is not using. The host can then ask for a swap. The swap takes effect at the next sample-period start strobe, the active-bank flag toggles, and the request bit clears itself.

Top module: `coef_dbuf_store`

## Requirements
- R1: After reset the control register reads 0x00 (bank A active, adaptive off, no swap pending), and every coefficient in both banks is zero.
- R2: The engine port returns the coefficient at index `eng_idx` (0 selects C1, 69 selects C70) from the active bank, one clock after the index is presented. An index of 70 or more returns zero.
- R3: Host byte addresses are laid out as follows. Bit 8 selects the bank (0 = A, 1 = B). Bits 7:0 give the byte offset 3*(n-1)+k for coefficient Cn, where k=0 is bits 23:16, k=1 is bits 15:8 and k=2 is bits 7:0. Bytes k=0 and k=1 are only staged. The whole 24-bit value enters the bank when byte k=2 is written, so the engine never sees a partly written coefficient.
- R4: While `run` is low, host writes and reads reach the bank selected by address bit 8.
- R5: While `run` is high and adaptive mode is on, host coefficient writes and reads reach the inactive bank, whatever address bit 8 says.
- R6: While `run` is high and adaptive mode is off, host coefficient writes change nothing and host coefficient reads return 0x00.
- R7: A swap request made while running in adaptive mode stays pending until the next cycle with `sample_start` high. In that cycle the active bank toggles and the request bit returns to 0.
- R8: A swap request written while `run` is low or adaptive mode is off is dropped, and the request bit reads 0. A pending request is also dropped if either condition is lost.
- R9: The control register sits at address 0x200. Bit 0 is the swap request (writing 1 requests a swap). Bit 1 is the active-bank flag (read-only, 0 = A, 1 = B). Bit 2 is adaptive enable (read/write). Host read data appears one clock after the read strobe.
- R10: Coefficient values from 0x800000 through 0x7FFFFF are stored bit-exact at C1 through C70. Byte offsets 210 and above are ignored on write and read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Filter engine running |
| sample_start | input | 1 | Start of a sample period, one-cycle strobe |
| host_we | input | 1 | Host byte write strobe |
| host_re | input | 1 | Host byte read strobe |
| host_addr | input | 10 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid one clock after `host_re` |
| eng_idx | input | 7 | Engine coefficient index, 0-based |
| eng_coef | output | 24 | Active-bank coefficient, one clock after `eng_idx` |

## Verification
Each result has a fixed delay. A host read, an engine read and a control-register update each take exactly one clock after the strobe or index that causes them. A coefficient becomes visible only one clock after its third byte, and a swap shows only one clock after the `sample_start` cycle that serves it. The bench drives every input on a falling edge and samples on the next falling edge, which is one full rising edge later and exactly when each registered result is due. The checks that nothing happens too early are placed before the event that triggers the change: after two of the three bytes, and after a swap request but before the strobe.

// File: rtl/coef_store_pkg.sv
package coef_store_pkg;

    localparam int NUM_COEF       = 70;
    localparam int COEF_W         = 24;
    localparam int BYTE_W         = 8;
    localparam int BYTES_PER_COEF = COEF_W / BYTE_W;
    localparam int BANK_BYTES     = NUM_COEF * BYTES_PER_COEF;
    localparam int IDX_W          = $clog2(NUM_COEF);
    localparam int BOFF_W         = $clog2(BANK_BYTES);
    localparam int HOST_AW        = BOFF_W + 2;
    localparam logic [HOST_AW-1:0] CTRL_ADDR = HOST_AW'(1) << (HOST_AW - 1);

    typedef logic [COEF_W-1:0] coef_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        BANK_A = 1'b0,
        BANK_B = 1'b1
    } bank_e;

    // Control register image: bit2 adaptive, bit1 active bank, bit0 swap request
    typedef struct packed {
        logic  adaptive;
        bank_e active;
        logic  swap_req;
    } ctrl_t;

    typedef struct packed {
        logic             valid;
        bank_e            bank;
        logic [IDX_W-1:0] idx;
        logic [1:0]       off;
    } coef_loc_t;

    function automatic coef_loc_t decode_loc(input logic [HOST_AW-1:0] a);
        coef_loc_t        loc;
        logic [BOFF_W-1:0] bo;
        bo        = a[BOFF_W-1:0];
        loc.valid = !a[HOST_AW-1] && (int'(bo) < BANK_BYTES);
        loc.bank  = bank_e'(a[BOFF_W]);
        loc.idx   = IDX_W'(bo / BOFF_W'(BYTES_PER_COEF));
        loc.off   = 2'(bo % BOFF_W'(BYTES_PER_COEF));
        return loc;
    endfunction

    function automatic byte_t coef_byte(input coef_t c, input logic [1:0] off);
        byte_t b;
        case (off)
            2'd0:    b = c[COEF_W-1 -: BYTE_W];
            2'd1:    b = c[COEF_W-1-BYTE_W -: BYTE_W];
            default: b = c[BYTE_W-1:0];
        endcase
        return b;
    endfunction

endpackage

// File: rtl/coef_bank.sv
module coef_bank #(
    parameter int N  = 70,
    parameter int W  = 24,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] ridx_eng,
    output logic [W-1:0]  rdata_eng,
    input  logic [IW-1:0] ridx_host,
    output logic [W-1:0]  rdata_host
);

    logic [W-1:0] mem [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) mem[i] <= '0;
        end else if (we && (int'(widx) < N)) begin
            mem[widx] <= wdata;
        end
    end

    always_comb begin
        rdata_eng  = (int'(ridx_eng)  < N) ? mem[ridx_eng]  : '0;
        rdata_host = (int'(ridx_host) < N) ? mem[ridx_host] : '0;
    end

endmodule

// File: rtl/coef_swap_ctrl.sv
module coef_swap_ctrl
    import coef_store_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    input  logic  sample_start,
    input  logic  ctrl_we,
    input  byte_t ctrl_wdata,
    output ctrl_t ctrl
);

    ctrl_t ctrl_nxt;

    always_comb begin
        ctrl_nxt = ctrl;
        if (ctrl_we) begin
            ctrl_nxt.adaptive = ctrl_wdata[2];
            if (ctrl_wdata[0]) ctrl_nxt.swap_req = 1'b1;
        end
        if (sample_start && ctrl.swap_req) begin
            ctrl_nxt.active   = bank_e'(~ctrl.active);
            ctrl_nxt.swap_req = 1'b0;
        end
        if (!(ctrl_nxt.adaptive && run)) ctrl_nxt.swap_req = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl <= '0;
        else     ctrl <= ctrl_nxt;
    end

    p_swap_toggles_r7: assert property (@(posedge clk) disable iff (rst)
        (sample_start && ctrl.swap_req) |=> (ctrl.active != $past(ctrl.active)));

    p_swap_clears_req_r7: assert property (@(posedge clk) disable iff (rst)
        (sample_start && ctrl.swap_req) |=> !ctrl.swap_req);

    p_no_swap_without_req_r7: assert property (@(posedge clk) disable iff (rst)
        !(sample_start && ctrl.swap_req) |=> $stable(ctrl.active));

    p_req_dropped_when_stopped_r8: assert property (@(posedge clk) disable iff (rst)
        !run |=> !ctrl.swap_req);

endmodule

// File: rtl/coef_host_port.sv
module coef_host_port
    import coef_store_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  ctrl_t              ctrl,
    input  logic               host_we,
    input  logic               host_re,
    input  logic [HOST_AW-1:0] host_addr,
    input  byte_t              host_wdata,
    output logic [1:0]         bank_we,
    output logic [IDX_W-1:0]   acc_idx,
    output coef_t              wcoef,
    output bank_e              rd_bank,
    output logic [1:0]         rd_off,
    output logic               rd_ok,
    output logic               ctrl_we,
    output logic               ctrl_re
);

    coef_loc_t loc;
    logic      locked;
    logic      acc_ok;
    bank_e     tgt;
    byte_t     stage_hi;
    byte_t     stage_mid;

    always_comb begin
        loc     = decode_loc(host_addr);
        locked  = run && !ctrl.adaptive;
        acc_ok  = loc.valid && !locked;
        tgt     = run ? bank_e'(~ctrl.active) : loc.bank;
        acc_idx = loc.idx;
        wcoef   = {stage_hi, stage_mid, host_wdata};
        bank_we = '0;
        if (host_we && acc_ok && loc.off == 2'd2) bank_we[tgt] = 1'b1;
        rd_ok   = host_re && acc_ok;
        rd_bank = tgt;
        rd_off  = loc.off;
        ctrl_we = host_we && (host_addr == CTRL_ADDR);
        ctrl_re = host_re && (host_addr == CTRL_ADDR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_hi  <= '0;
            stage_mid <= '0;
        end else if (host_we && acc_ok) begin
            if (loc.off == 2'd0) stage_hi  <= host_wdata;
            if (loc.off == 2'd1) stage_mid <= host_wdata;
        end
    end

    p_one_bank_write_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_we));

    p_locked_no_write_r6: assert property (@(posedge clk) disable iff (rst)
        (run && !ctrl.adaptive) |-> (bank_we == 2'b00));

    p_steer_inactive_r5: assert property (@(posedge clk) disable iff (rst)
        (run && (bank_we != 2'b00)) |-> !bank_we[ctrl.active]);

endmodule

// File: rtl/coef_dbuf_store.sv
module coef_dbuf_store
    import coef_store_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               sample_start,
    input  logic               host_we,
    input  logic               host_re,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [BYTE_W-1:0]  host_wdata,
    output logic [BYTE_W-1:0]  host_rdata,
    input  logic [IDX_W-1:0]   eng_idx,
    output logic [COEF_W-1:0]  eng_coef
);

    localparam int NUM_BANKS = 2;

    ctrl_t              ctrl;
    logic [1:0]         bank_we;
    logic [IDX_W-1:0]   acc_idx;
    coef_t              wcoef;
    bank_e              rd_bank;
    logic [1:0]         rd_off;
    logic               rd_ok;
    logic               ctrl_we;
    logic               ctrl_re;
    coef_t              eng_rd  [NUM_BANKS];
    coef_t              host_rd [NUM_BANKS];
    byte_t              rdata_nxt;

    coef_host_port u_host (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .ctrl       (ctrl),
        .host_we    (host_we),
        .host_re    (host_re),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .bank_we    (bank_we),
        .acc_idx    (acc_idx),
        .wcoef      (wcoef),
        .rd_bank    (rd_bank),
        .rd_off     (rd_off),
        .rd_ok      (rd_ok),
        .ctrl_we    (ctrl_we),
        .ctrl_re    (ctrl_re)
    );

    coef_swap_ctrl u_swap (
        .clk          (clk),
        .rst          (rst),
        .run          (run),
        .sample_start (sample_start),
        .ctrl_we      (ctrl_we),
        .ctrl_wdata   (host_wdata),
        .ctrl         (ctrl)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        coef_bank #(
            .N  (NUM_COEF),
            .W  (COEF_W),
            .IW (IDX_W)
        ) u_bank (
            .clk        (clk),
            .rst        (rst),
            .we         (bank_we[g]),
            .widx       (acc_idx),
            .wdata      (wcoef),
            .ridx_eng   (eng_idx),
            .rdata_eng  (eng_rd[g]),
            .ridx_host  (acc_idx),
            .rdata_host (host_rd[g])
        );
    end

    always_comb begin
        rdata_nxt = '0;
        if (ctrl_re)    rdata_nxt = byte_t'(ctrl);
        else if (rd_ok) rdata_nxt = coef_byte(host_rd[rd_bank], rd_off);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rdata <= '0;
            eng_coef   <= '0;
        end else begin
            host_rdata <= rdata_nxt;
            eng_coef   <= eng_rd[ctrl.active];
        end
    end

    p_locked_read_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (host_re && run && !ctrl.adaptive && host_addr != CTRL_ADDR) |=> (host_rdata == '0));

endmodule

// File: tb/coef_dbuf_store_tb.sv
module coef_dbuf_store_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic        sample_start = 1'b0;
    logic        host_we = 1'b0;
    logic        host_re = 1'b0;
    logic [9:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [6:0]  eng_idx = '0;
    logic [23:0] eng_coef;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [9:0] CTRL = 10'h200;

    always #10 clk = ~clk;

    coef_dbuf_store dut_i (
        .clk          (clk),
        .rst          (rst),
        .run          (run),
        .sample_start (sample_start),
        .host_we      (host_we),
        .host_re      (host_re),
        .host_addr    (host_addr),
        .host_wdata   (host_wdata),
        .host_rdata   (host_rdata),
        .eng_idx      (eng_idx),
        .eng_coef     (eng_coef)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic hw(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hr(input logic [9:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_re = 1'b1;
        @(negedge clk);
        host_re = 1'b0;
        d = host_rdata;
    endtask

    function automatic logic [9:0] caddr(input bit b, input int n, input int k);
        return 10'((b ? 256 : 0) + 3 * (n - 1) + k);
    endfunction

    task automatic wr_coef(input bit b, input int n, input logic [23:0] v);
        hw(caddr(b, n, 0), v[23:16]);
        hw(caddr(b, n, 1), v[15:8]);
        hw(caddr(b, n, 2), v[7:0]);
    endtask

    task automatic rd_coef(input bit b, input int n, output logic [23:0] v);
        logic [7:0] x;
        hr(caddr(b, n, 0), x); v[23:16] = x;
        hr(caddr(b, n, 1), x); v[15:8]  = x;
        hr(caddr(b, n, 2), x); v[7:0]   = x;
    endtask

    task automatic eng_rd(input int n, output logic [23:0] v);
        @(negedge clk);
        eng_idx = 7'(n - 1);
        @(negedge clk);
        v = eng_coef;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        sample_start = 1'b1;
        @(negedge clk);
        sample_start = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] b; logic [23:0] c;
        hr(CTRL, b);      check("R1 ctrl after reset", 32'(b), 32'h00);
        eng_rd(1, c);     check("R1 C1 after reset", 32'(c), 32'h0);
        rd_coef(1, 70, c); check("R1 bank B C70 after reset", 32'(c), 32'h0);
    endtask

    task automatic t_stopped_direct();
        logic [23:0] c;
        wr_coef(0, 1, 24'h123456);
        wr_coef(1, 1, 24'h654321);
        rd_coef(0, 1, c); check("R4 R9 bank A C1 read", 32'(c), 32'h123456);
        rd_coef(1, 1, c); check("R4 bank B C1 read", 32'(c), 32'h654321);
        eng_rd(1, c);     check("R2 engine C1 from bank A", 32'(c), 32'h123456);
        eng_rd(71, c);    check("R2 engine index out of range", 32'(c), 32'h0);
    endtask

    task automatic t_staging();
        logic [23:0] c;
        wr_coef(0, 5, 24'hAABBCC);
        hw(caddr(0, 5, 0), 8'h11);
        hw(caddr(0, 5, 1), 8'h22);
        eng_rd(5, c); check("R3 partial write not visible", 32'(c), 32'hAABBCC);
        hw(caddr(0, 5, 2), 8'h33);
        eng_rd(5, c); check("R3 commit on last byte", 32'(c), 32'h112233);
    endtask

    task automatic t_range();
        logic [23:0] c; logic [7:0] b;
        wr_coef(0, 70, 24'h800000);
        wr_coef(0, 69, 24'h7FFFFF);
        eng_rd(70, c); check("R10 C70 min value", 32'(c), 32'h800000);
        eng_rd(69, c); check("R10 C69 max value", 32'(c), 32'h7FFFFF);
        hw(10'd210, 8'h5A);
        hr(10'd210, b); check("R10 byte offset 210 ignored", 32'(b), 32'h00);
        eng_rd(70, c); check("R10 C70 intact after bad write", 32'(c), 32'h800000);
    endtask

    task automatic t_swap_ignored();
        logic [7:0] b; logic [23:0] c;
        hw(CTRL, 8'h01);
        hr(CTRL, b); check("R8 request while stopped", 32'(b), 32'h00);
        run = 1'b1;
        hw(CTRL, 8'h01);
        hr(CTRL, b); check("R8 request with adaptive off", 32'(b), 32'h00);
        pulse_start();
        hr(CTRL, b); check("R8 no swap after strobe", 32'(b), 32'h00);
        eng_rd(1, c); check("R8 engine still bank A", 32'(c), 32'h123456);
    endtask

    task automatic t_locked();
        logic [7:0] b; logic [23:0] c;
        wr_coef(0, 1, 24'hDEAD01);
        hr(caddr(0, 1, 0), b); check("R6 locked read returns zero", 32'(b), 32'h00);
        run = 1'b0;
        rd_coef(0, 1, c); check("R6 locked write ignored", 32'(c), 32'h123456);
    endtask

    task automatic t_steer_and_swap();
        logic [7:0] b; logic [23:0] c;
        run = 1'b1;
        hw(CTRL, 8'h04);
        hr(CTRL, b); check("R9 adaptive bit readback", 32'(b), 32'h04);
        wr_coef(0, 1, 24'h0A0B0C);
        eng_rd(1, c); check("R5 active bank untouched", 32'(c), 32'h123456);
        rd_coef(0, 1, c); check("R5 read steered to inactive B", 32'(c), 32'h0A0B0C);
        hw(CTRL, 8'h05);
        hr(CTRL, b); check("R7 request pending", 32'(b), 32'h05);
        eng_rd(1, c); check("R7 no swap before strobe", 32'(c), 32'h123456);
        pulse_start();
        hr(CTRL, b); check("R7 flag toggled and request cleared", 32'(b), 32'h06);
        eng_rd(1, c); check("R7 engine now on bank B", 32'(c), 32'h0A0B0C);
        wr_coef(1, 1, 24'h111111);
        eng_rd(1, c); check("R5 bank B in use unchanged", 32'(c), 32'h0A0B0C);
        hw(CTRL, 8'h01);
        hr(CTRL, b); check("R8 request with adaptive cleared", 32'(b), 32'h02);
        run = 1'b0;
        rd_coef(0, 1, c); check("R5 write landed in bank A", 32'(c), 32'h111111);
        rd_coef(1, 1, c); check("R4 bank B C1 after swap", 32'(c), 32'h0A0B0C);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_stopped_direct();
        t_staging();
        t_range();
        t_swap_ignored();
        t_locked();
        t_steer_and_swap();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule